// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block sends one byte from an I2C master: either a data byte, or an address byte whose bit 0 is the read/write flag. It drives SCL and SDA as open-drain pins and then reads the slave's acknowledge during a ninth clock. Start and stop conditions come from other logic. The block expects to be handed a bus whose SCL is already low and whose SDA is free.

A host writes a byte into the transmit buffer. That write latches a baud reload value and starts a phase counter. The counter times the SCL low and high phases. Each phase lasts one rollover of the counter. After the ninth clock, SCL stays low and the counter stops until the next buffer write.

The block reports four flags:
- buffer full;
- a sticky write collision, set by a write made while a transfer is running;
- the acknowledge status;
- a completion flag, cleared by a write-one-to-clear strobe.

Top module: `i2c_byte_tx`

## Requirements
- R1: After reset, SCL is pulled low (`sclOe`=1) and SDA is released (`sdaOe`=0). `bufFull`, `wrCol`, `ackStat` and `doneIrq` are all 0.
- R2: A write while idle sets `bufFull` in the next cycle and starts nine SCL clocks. Each low phase and each high phase lasts P system clocks, where P = max(reload,1)+1. The first low phase is counted from the write's clock edge.
- R3: The byte goes out MSB first. A 0 bit pulls SDA low (`sdaOe`=1) and a 1 bit releases it. SDA never changes while SCL is high. For bits 2 to 8, SDA changes exactly one system clock after SCL falls.
- R4: `bufFull` is still 1 after the seventh SCL falling edge and is 0 after the eighth. SDA is released one clock after the eighth falling edge, leaving the bus free for the acknowledge.
- R5: On the ninth falling edge, `ackStat` takes the level read on `sdaIn`: 0 for ACK (slave holds SDA low), 1 for NACK.
- R6: After the ninth falling edge, `doneIrq` is set, SCL stays low and SDA stays released. No further SCL pulse appears until the next buffer write.
- R7: A write while a transfer runs sets `wrCol`. The shifted byte is unchanged and the transfer's timing is unaffected.
- R8: `wrCol` stays set, including across later transfers, until `colClr` is pulsed. A new collision in the same cycle as `colClr` keeps it set.
- R9: `doneIrq` is cleared only by `doneClr`. A new buffer write leaves it set.
- R10: The reload value is sampled at the buffer write. Changing `baudReload` during a transfer has no effect on that transfer.
- R11: A reload value of 0 is treated as 1, so a phase is never shorter than two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Transmit buffer write strobe |
| wrData | input | DATA_W | Byte to send (MSB first) |
| baudReload | input | RELOAD_W | Baud counter reload value |
| colClr | input | 1 | Clear strobe for the collision flag |
| doneClr | input | 1 | Write-one-to-clear strobe for the completion flag |
| sdaIn | input | 1 | SDA pin readback |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| bufFull | output | 1 | Transmit buffer full |
| wrCol | output | 1 | Sticky write collision flag |
| ackStat | output | 1 | Acknowledge status (1 = NACK) |
| doneIrq | output | 1 | Transfer complete flag |

## Verification
The bench keeps the default widths, an 8-bit byte and a 7-bit reload. It sweeps reload values 0 to 4, which gives phase lengths of 2, 2, 3, 4 and 5 clocks. Those short phases make the clamp at zero and the one-clock SDA hold lag visible at exact cycle counts.

Each reload value is combined with all-zero, all-one and alternating byte patterns, and with both ACK and NACK answers from a modelled slave. Further transfers inject a buffer write and a reload change midway through a transfer. Those cases exercise the collision, the frozen period and sticky-flag behaviour while the bench measures every SCL phase.

// File: rtl/i2c_byte_tx_pkg.sv
package i2c_byte_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } txState_t;

  // Strobes issued by the control module to the datapath
  typedef struct packed {
    logic load;    // accepted buffer write
    logic drive;   // put next data bit on SDA
    logic relSda;  // let go of SDA for acknowledge
    logic bfClr;   // eighth falling edge
    logic sample;  // ninth falling edge
  } txStrobe_t;

endpackage

// File: rtl/i2c_byte_tx_ctrl.sv
module i2c_byte_tx_ctrl
  import i2c_byte_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [RELOAD_W-1:0] baudReload,
  output txStrobe_t           stb,
  output logic                sclOe,
  output logic                busy
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_W - 1);

  txState_t            state;
  logic [RELOAD_W-1:0] cnt;
  logic [RELOAD_W-1:0] period;
  logic [BIT_W-1:0]    bitIdx;
  logic                drivePend;
  logic [RELOAD_W-1:0] effReload;
  logic                tick;
  logic                fallNow;

  assign effReload = (baudReload == '0) ? RELOAD_W'(1) : baudReload;
  assign tick      = (cnt == '0);
  assign fallNow   = (state == ST_HIGH) && tick;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stb        = '0;
    stb.load   = (state == ST_IDLE) && wrEn;
    stb.drive  = drivePend && (bitIdx < LAST_BIT);
    stb.relSda = drivePend && (bitIdx == LAST_BIT);
    stb.bfClr  = fallNow && (bitIdx == DATA_LAST);
    stb.sample = fallNow && (bitIdx == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      period    <= RELOAD_W'(1);
      bitIdx    <= '0;
      sclOe     <= 1'b1;
      drivePend <= 1'b0;
    end else begin
      drivePend <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wrEn) begin
            state  <= ST_LOW;
            cnt    <= effReload;
            period <= effReload;
            bitIdx <= '0;
          end
        end
        ST_LOW: begin
          if (tick) begin
            state <= ST_HIGH;
            cnt   <= period;
            sclOe <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclOe <= 1'b1;
            cnt   <= period;
            if (bitIdx == LAST_BIT) begin
              state <= ST_IDLE;
            end else begin
              state     <= ST_LOW;
              bitIdx    <= bitIdx + 1'b1;
              drivePend <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_SCL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> sclOe); // R6

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= LAST_BIT); // R2

  AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.sample) |=> $stable(period)); // R10

endmodule

// File: rtl/i2c_byte_tx_dp.sv
module i2c_byte_tx_dp
  import i2c_byte_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic              busy,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              colClr,
  input  logic              doneClr,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              bufFull,
  output logic              wrCol,
  output logic              ackStat,
  output logic              doneIrq
);
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      sdaOe   <= 1'b0;
      bufFull <= 1'b0;
      wrCol   <= 1'b0;
      ackStat <= 1'b0;
      doneIrq <= 1'b0;
    end else begin
      if (stb.load) begin
        shReg <= wrData;
        sdaOe <= ~wrData[DATA_W-1];
      end else if (stb.drive) begin
        shReg <= shReg << 1;
        sdaOe <= ~shReg[DATA_W-2];
      end else if (stb.relSda) begin
        sdaOe <= 1'b0;
      end

      if (stb.load)       bufFull <= 1'b1;
      else if (stb.bfClr) bufFull <= 1'b0;

      if (wrEn && busy) wrCol <= 1'b1;
      else if (colClr)  wrCol <= 1'b0;

      if (stb.sample) ackStat <= sdaIn;

      if (stb.sample)   doneIrq <= 1'b1;
      else if (doneClr) doneIrq <= 1'b0;
    end
  end

  AST_COL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wrCol && !colClr) |=> wrCol); // R8

  AST_BUF_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && !stb.drive) |=> $stable(shReg)); // R7

  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |-> !sdaOe); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && !doneClr) |=> doneIrq); // R9

endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx
  import i2c_byte_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [RELOAD_W-1:0] baudReload,
  input  logic                colClr,
  input  logic                doneClr,
  input  logic                sdaIn,
  output logic                sclOe,
  output logic                sdaOe,
  output logic                bufFull,
  output logic                wrCol,
  output logic                ackStat,
  output logic                doneIrq
);
  txStrobe_t stb;
  logic      busy;

  i2c_byte_tx_ctrl #(
    .DATA_W  (DATA_W),
    .RELOAD_W(RELOAD_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .baudReload(baudReload),
    .stb       (stb),
    .sclOe     (sclOe),
    .busy      (busy)
  );

  i2c_byte_tx_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .busy   (busy),
    .wrEn   (wrEn),
    .wrData (wrData),
    .colClr (colClr),
    .doneClr(doneClr),
    .sdaIn  (sdaIn),
    .sdaOe  (sdaOe),
    .bufFull(bufFull),
    .wrCol  (wrCol),
    .ackStat(ackStat),
    .doneIrq(doneIrq)
  );

  AST_SDA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && !$past(sclOe)) |-> $stable(sdaOe)); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> (sclOe && !sdaOe)); // R6

endmodule

// File: tb/sim_i2c_byte_tx.sv
module sim_i2c_byte_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [6:0] baudReload = '0;
  logic       colClr = 1'b0;
  logic       doneClr = 1'b0;
  logic       ackLow = 1'b0;
  logic       sdaIn;
  logic       sclOe, sdaOe, bufFull, wrCol, ackStat, doneIrq;

  int checks = 0;
  int errors = 0;

  assign sdaIn = !(sdaOe || ackLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_tx u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .baudReload(baudReload), .colClr(colClr), .doneClr(doneClr),
    .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .bufFull(bufFull),
    .wrCol(wrCol), .ackStat(ackStat), .doneIrq(doneIrq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One transfer; optional disturbing write (and reload change) at cycle colAt
  task automatic runXfer(input logic [7:0] d, input int r, input bit nack,
                         input bit expDone, input int colAt,
                         input logic [7:0] colData, input int r2);
    int p;
    int phase;
    int rises;
    int falls;
    int timErr;
    int sdaErr;
    int idleErr;
    logic [7:0] cap;
    logic prevS;
    logic prevSd;
    logic s;
    logic sd;
    bit done;
    string tReq;
    p = ((r < 1) ? 1 : r) + 1;
    tReq = (r2 != r) ? "R10" : ((r == 0) ? "R11" : "R2");
    phase = 0; rises = 0; falls = 0; timErr = 0; sdaErr = 0; idleErr = 0;
    cap = '0; done = 0; prevS = 1'b1; prevSd = 1'b0;
    @(negedge clk);
    wrData = d; baudReload = 7'(r); wrEn = 1'b1;
    for (int cyc = 1; cyc <= 22 * p + 10; cyc++) begin
      @(negedge clk);
      if (cyc == colAt) begin
        wrEn = 1'b1; wrData = colData; baudReload = 7'(r2);
      end else begin
        wrEn = 1'b0;
      end
      s = sclOe; sd = sdaOe;
      if (cyc == 1) begin
        chk(bufFull == 1'b1, "R2 bufFull after write", int'(bufFull), 1);
        chk(doneIrq == expDone, "R9 doneIrq across write", int'(doneIrq), int'(expDone));
        phase = 1; prevS = s; prevSd = sd;
        continue;
      end
      if (s != prevS) begin
        if (done) idleErr++;
        else if (phase != p) timErr++;
        phase = 1;
        if (!s) begin
          rises++;
          if (rises <= 8) cap = {cap[6:0], !sd};
        end else begin
          falls++;
          if (falls == 7) chk(bufFull == 1'b1, "R4 bufFull before 8th fall", int'(bufFull), 1);
          if (falls == 8) begin
            chk(bufFull == 1'b0, "R4 bufFull at 8th fall", int'(bufFull), 0);
            ackLow = !nack;
          end
          if (falls == 9) begin
            chk(doneIrq == 1'b1, "R6 doneIrq set", int'(doneIrq), 1);
            chk(ackStat == nack, "R5 ackStat", int'(ackStat), int'(nack));
            ackLow = 1'b0;
            done = 1;
          end
        end
      end else begin
        phase++;
      end
      if (sd != prevSd) begin
        if (!s) sdaErr++;
        else if (falls > 0 && phase != 2) sdaErr++;
      end
      if (falls == 8 && s && phase == 2 && !done)
        chk(sd == 1'b0, "R4 SDA released for ack", int'(sd), 0);
      prevS = s; prevSd = sd;
    end
    chk(timErr == 0 && rises == 9, {tReq, " SCL phase timing"}, timErr * 100 + rises, 9);
    chk(cap == d, (colAt > 0) ? "R7 byte unchanged" : "R3 byte on SDA", int'(cap), int'(d));
    chk(sdaErr == 0, "R3 SDA change timing", sdaErr, 0);
    chk(idleErr == 0 && sclOe && !sdaOe, "R6 idle after ninth clock",
        idleErr * 4 + int'(sclOe) * 2 + int'(sdaOe), 2);
  endtask

  task automatic clearDone();
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
    chk(doneIrq == 1'b0, "R9 doneClr clears", int'(doneIrq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sclOe == 1'b1, "R1 sclOe", int'(sclOe), 1);
    chk(sdaOe == 1'b0, "R1 sdaOe", int'(sdaOe), 0);
    chk({bufFull, wrCol, ackStat, doneIrq} == 4'b0, "R1 flags",
        int'({bufFull, wrCol, ackStat, doneIrq}), 0);

    // Sweep of reload values, byte patterns and acknowledge answers
    for (int r = 0; r <= 4; r++) begin
      for (int k = 0; k < 5; k++) begin
        logic [7:0] pat;
        case (k)
          0: pat = 8'h00;
          1: pat = 8'hFF;
          2: pat = 8'hA5;
          3: pat = 8'h5A;
          default: pat = 8'h81;
        endcase
        runXfer(pat, r, ((r + k) % 2) == 1, 1'b0, 0, 8'h00, r);
        clearDone();
      end
    end

    // R9: completion flag stays set across a new buffer write
    runXfer(8'h3C, 2, 1'b0, 1'b0, 0, 8'h00, 2);
    runXfer(8'hC3, 2, 1'b1, 1'b1, 0, 8'h00, 2);
    clearDone();

    // R7 and R10: collision write with a reload change mid-transfer
    runXfer(8'h96, 3, 1'b0, 1'b0, 9, 8'h69, 1);
    chk(wrCol == 1'b1, "R7 wrCol set", int'(wrCol), 1);
    clearDone();

    // R8: collision flag survives a clean transfer
    runXfer(8'h0F, 1, 1'b1, 1'b0, 0, 8'h00, 1);
    chk(wrCol == 1'b1, "R8 wrCol sticky", int'(wrCol), 1);
    clearDone();

    // R8: set wins over a clear in the same cycle
    runXfer(8'hF0, 2, 1'b0, 1'b0, 5, 8'h11, 2);
    clearDone();
    @(negedge clk); colClr = 1'b1;
    @(negedge clk); colClr = 1'b0;
    chk(wrCol == 1'b0, "R8 colClr clears", int'(wrCol), 0);
    @(negedge clk); wrData = 8'h55; baudReload = 7'd2; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b1; colClr = 1'b1; wrData = 8'hAA;
    @(negedge clk); wrEn = 1'b0; colClr = 1'b0;
    chk(wrCol == 1'b1, "R8 collision beats clear", int'(wrCol), 1);
    repeat (60) @(negedge clk);
    chk(doneIrq == 1'b1 && sclOe, "R6 done after overlap test", int'(doneIrq), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule